// File: doc/BRIEF.md
# Character-Cell Raster Position Generator

This block places a grid of character cells on a video raster for an on-screen text overlay. The grid is 40 cells across and 17 text lines down. Each cell is 12 dots wide and 13 dots tall. The block counts scan lines from a vertical sync strobe and display-clock periods from a horizontal sync strobe. It decides when the grid is being drawn and reports which cell and which dot inside that cell belong to the current display clock. A font lookup and colour stage downstream use these coordinates.

The vertical start is given in scan lines and the horizontal start in display clocks. Any value below the legal floor is raised to that floor, and an error flag records that this happened. Each text line has its own double-width bit and its own double-height bit. All of these settings are captured at vertical sync and held for the whole frame. The sync strobes and the display-clock enable are single-cycle pulses in the `clk` domain.

Top module: `osd_cell_timer`

## Requirements
- R1: While reset is held, and after it is released but before the first vertical sync, `active` is 0, the coordinate outputs are 0 and `cfg_err` is 0.
- R2: Scan line k is the line opened by the k-th `hsync` after `vsync`. Text line 0, dot row 0, is drawn on scan line `vstart`. Any `vstart` below 0x14 is treated as 0x14.
- R3: Let S = max(`hstart`, 0x19) + 9. After an `hsync`, `active` rises in the cycle after the S-th `dclk_en` pulse, with `col` = 0 and `dot_x` = 0.
- R4: While `active` is high, each `dclk_en` pulse advances `dot_x` through 0..11 and then `col` through 0..39. After column 39, dot 11, `active` stays low until the next `hsync`, and every `hsync` makes `active` low in the following cycle.
- R5: If bit r of `hdbl` (1 = double width) is set for the current text line r, every dot lasts two `dclk_en` pulses, so one cell takes 24 pulses.
- R6: Each text line has dot rows 0..12, one per scan line. Text lines follow one another with no gap. After text line 16 ends, `active` stays low until the next frame.
- R7: If bit r of `vdbl` (1 = double height) is set, each dot row of text line r lasts two scan lines, so the line takes 26 scan lines. The next text line starts on the scan line right after it.
- R8: `vstart`, `hstart`, `hdbl` and `vdbl` are sampled only in a `vsync` cycle. Changing them at any other time does not affect the frame in progress.
- R9: `cfg_err` is updated only at `vsync`. It becomes 1 when `vstart` < 0x14 or `hstart` < 0x19 at that moment, and 0 otherwise.
- R10: When two strobes arrive in the same cycle, `vsync` takes precedence over `hsync`, and `hsync` takes precedence over `dclk_en`; the strobe that loses has no effect. Cycles with no strobe change nothing.
- R11: Whenever `active` is 0, `col`, `row`, `dot_x` and `dot_y` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync strobe, one cycle |
| vsync | input | 1 | Vertical sync strobe, one cycle |
| dclk_en | input | 1 | Display-clock enable, one pulse per dot clock |
| vstart | input | 8 | Vertical start, in scan lines |
| hstart | input | 9 | Horizontal start, in display clocks, before the fixed offset of 9 |
| hdbl | input | 17 | Per-text-line double-width bits |
| vdbl | input | 17 | Per-text-line double-height bits |
| active | output | 1 | A grid dot is being drawn |
| col | output | 6 | Cell column, 0..39 |
| row | output | 5 | Text line, 0..16 |
| dot_x | output | 4 | Dot column inside the cell, 0..11 |
| dot_y | output | 4 | Dot row inside the cell, 0..12 |
| cfg_err | output | 1 | A start value was clamped at the last vsync |

## Verification
A wrong horizontal count shows at the ports on the first visible scan line. Either `active` rises on the wrong `dclk_en` pulse, or `dot_x` and `col` step at the wrong pulse; both are seen one cycle after the pulse that caused them. A wrong vertical count or a missed double-height pairing does not show until the next `hsync`. From then on, every later text line of the frame carries a wrong `row` or `dot_y`. Clamping or sampling faults appear only after the `vsync` that loads the settings, so the bench changes the settings in the middle of a frame and also writes illegal start values.

// File: rtl/osd_cell_timer.sv
module osd_cell_timer #(
  parameter int COLS   = 40,
  parameter int ROWS   = 17,
  parameter int CELL_W = 12,
  parameter int CELL_H = 13,
  parameter int VPW    = 8,
  parameter int HPW    = 9,
  parameter int VP_MIN = 20,
  parameter int HP_MIN = 25,
  parameter int H_OFS  = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hsync,
  input  logic                      vsync,
  input  logic                      dclk_en,
  input  logic [VPW-1:0]            vstart,
  input  logic [HPW-1:0]            hstart,
  input  logic [ROWS-1:0]           hdbl,
  input  logic [ROWS-1:0]           vdbl,
  output logic                      active,
  output logic [$clog2(COLS)-1:0]   col,
  output logic [$clog2(ROWS)-1:0]   row,
  output logic [$clog2(CELL_W)-1:0] dot_x,
  output logic [$clog2(CELL_H)-1:0] dot_y,
  output logic                      cfg_err
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);
  localparam int XW = $clog2(CELL_W);
  localparam int YW = $clog2(CELL_H);
  localparam int LW = VPW + 1;
  localparam int HW = HPW + 1;

  logic [VPW-1:0]  vs_q;
  logic [HW-1:0]   hs_q;
  logic [ROWS-1:0] hd_q, vd_q;
  logic            err_q;
  logic [LW-1:0]   line_q;
  logic            vact, vsub;
  logic [RW-1:0]   row_q;
  logic [YW-1:0]   dy_q;
  logic [HW-1:0]   hcnt;
  logic            hact, hdone, hsub;
  logic [CW-1:0]   col_q;
  logic [XW-1:0]   dx_q;

  wire vlow = vstart < VPW'(VP_MIN);
  wire hlow = hstart < HPW'(HP_MIN);
  wire h_ev = hsync && !vsync;
  wire d_ev = dclk_en && !hsync && !vsync;
  wire line_sat = &line_q;
  wire [LW-1:0] line_nx = line_sat ? line_q : line_q + 1'b1;
  wire first_line = !line_sat && (line_nx == {1'b0, vs_q});
  wire v_step = !vd_q[row_q] || vsub;
  wire h_step = !hd_q[row_q] || hsub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q  <= VPW'(VP_MIN);
      hs_q  <= HW'(HP_MIN + H_OFS);
      hd_q  <= '0;
      vd_q  <= '0;
      err_q <= 1'b0;
    end else if (vsync) begin
      vs_q  <= vlow ? VPW'(VP_MIN) : vstart;
      hs_q  <= (hlow ? HW'(HP_MIN) : {1'b0, hstart}) + HW'(H_OFS);
      hd_q  <= hdbl;
      vd_q  <= vdbl;
      err_q <= vlow || hlow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     line_q <= '1;
    else if (vsync) line_q <= '0;
    else if (hsync) line_q <= line_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || vsync) begin
      vact  <= 1'b0;
      vsub  <= 1'b0;
      row_q <= '0;
      dy_q  <= '0;
    end else if (hsync) begin
      if (!vact && first_line) begin
        vact  <= 1'b1;
        vsub  <= 1'b0;
        row_q <= '0;
        dy_q  <= '0;
      end else if (vact) begin
        vsub <= vd_q[row_q] && !vsub;
        if (v_step) begin
          if (dy_q == YW'(CELL_H - 1)) begin
            dy_q <= '0;
            if (row_q == RW'(ROWS - 1)) begin
              vact  <= 1'b0;
              row_q <= '0;
            end else begin
              row_q <= row_q + 1'b1;
            end
          end else begin
            dy_q <= dy_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || h_ev) begin
      hcnt  <= '0;
      hact  <= 1'b0;
      hdone <= !rst_n;
      hsub  <= 1'b0;
      col_q <= '0;
      dx_q  <= '0;
    end else if (d_ev) begin
      if (hact) begin
        hsub <= hd_q[row_q] && !hsub;
        if (h_step) begin
          if (dx_q == XW'(CELL_W - 1)) begin
            dx_q <= '0;
            if (col_q == CW'(COLS - 1)) begin
              hact  <= 1'b0;
              hdone <= 1'b1;
              col_q <= '0;
            end else begin
              col_q <= col_q + 1'b1;
            end
          end else begin
            dx_q <= dx_q + 1'b1;
          end
        end
      end else if (!hdone) begin
        hcnt <= hcnt + 1'b1;
        if (hcnt + 1'b1 == hs_q) begin
          hact  <= 1'b1;
          hsub  <= 1'b0;
          col_q <= '0;
          dx_q  <= '0;
        end
      end
    end
  end

  assign active  = hact && vact;
  assign col     = active ? col_q : '0;
  assign row     = active ? row_q : '0;
  assign dot_x   = active ? dx_q : '0;
  assign dot_y   = active ? dy_q : '0;
  assign cfg_err = err_q;

  AST_HSYNC_BLANKS: assert property (@(posedge clk) disable iff (!rst_n) hsync |=> !active); // R4
  AST_VSYNC_BLANKS: assert property (@(posedge clk) disable iff (!rst_n) vsync |=> !active); // R2
  AST_START_CELL: assert property (@(posedge clk) disable iff (!rst_n) $rose(active) |-> (col == '0 && dot_x == '0)); // R3
  AST_ROW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !hsync && !vsync) |=> (!active || (row == $past(row) && dot_y == $past(dot_y)))); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dclk_en && !hsync && !vsync) |=> ($stable(active) && $stable(col) && $stable(dot_x))); // R10
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !vsync |=> $stable(cfg_err)); // R9
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (col == '0 && row == '0 && dot_x == '0 && dot_y == '0)); // R11
endmodule

// File: tb/sim_osd_cell_timer.sv
`timescale 1ns/1ps
module sim_osd_cell_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0, dclk_en = 1'b0;
  logic [7:0] vstart = 8'h14;
  logic [8:0] hstart = 9'h19;
  logic [16:0] hdbl = '0, vdbl = '0;
  logic active, cfg_err;
  logic [5:0] col;
  logic [4:0] row;
  logic [3:0] dot_x, dot_y;

  always #5 clk = ~clk;

  osd_cell_timer u0 (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .dclk_en(dclk_en),
    .vstart(vstart), .hstart(hstart), .hdbl(hdbl), .vdbl(vdbl),
    .active(active), .col(col), .row(row), .dot_x(dot_x), .dot_y(dot_y), .cfg_err(cfg_err));

  int checks = 0, fails = 0;
  string req = "R1";
  int m_line = -1, m_pulses = 1000000, m_vs = 20, m_hs = 34;
  logic [16:0] m_hd = '0, m_vd = '0;
  bit m_err = 0;

  task automatic model(input bit h, input bit v, input bit d);
    if (!rst_n) begin
      m_line = -1; m_pulses = 1000000; m_err = 0;
    end else if (v) begin
      m_vs = (vstart < 8'h14) ? 20 : int'(vstart);
      m_hs = ((hstart < 9'h19) ? 25 : int'(hstart)) + 9;
      m_hd = hdbl; m_vd = vdbl;
      m_err = (vstart < 8'h14) || (hstart < 9'h19);
      m_line = 0; m_pulses = 1000000;
    end else if (h) begin
      if (m_line >= 0) m_line++;
      m_pulses = 0;
    end else if (d) begin
      if (m_pulses < 1000000) m_pulses++;
    end
  endtask

  task automatic expected(output bit a, output int c, output int r, output int x, output int y);
    int left, p, w;
    bit found;
    a = 0; c = 0; r = 0; x = 0; y = 0;
    if (m_line < 0 || m_line < m_vs) return;
    left = m_line - m_vs;
    found = 0;
    for (int k = 0; k < 17 && !found; k++) begin
      int ht = m_vd[k] ? 26 : 13;
      if (left < ht) begin
        found = 1; r = k; y = m_vd[k] ? left / 2 : left;
      end else left -= ht;
    end
    if (!found || m_pulses < m_hs) begin r = 0; y = 0; return; end
    p = m_pulses - m_hs;
    w = m_hd[r] ? 24 : 12;
    if (p >= 40 * w) begin r = 0; y = 0; return; end
    a = 1; c = p / w; x = m_hd[r] ? (p % w) / 2 : p % w;
  endtask

  task automatic compare();
    bit ea; int ec, er, ex, ey;
    expected(ea, ec, er, ex, ey);
    checks++;
    if (active !== ea || col !== 6'(ec) || row !== 5'(er) || dot_x !== 4'(ex) ||
        dot_y !== 4'(ey) || cfg_err !== m_err) begin
      fails++;
      $display("FAIL %s: got act=%0b col=%0d row=%0d dx=%0d dy=%0d err=%0b exp act=%0b col=%0d row=%0d dx=%0d dy=%0d err=%0b",
               req, active, col, row, dot_x, dot_y, cfg_err, ea, ec, er, ex, ey, m_err);
    end
  endtask

  task automatic tick(input bit h, input bit v, input bit d);
    hsync = h; vsync = v; dclk_en = d;
    @(posedge clk);
    model(h, v, d);
    @(negedge clk);
    compare();
  endtask

  task automatic line(input int n);
    tick(1, 0, 0);
    for (int i = 0; i < n; i++) tick(0, 0, 1);
  endtask

  task automatic expect_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  initial begin
    #1900000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    req = "R1";
    for (int i = 0; i < 3; i++) tick(0, 0, 1);
    rst_n = 1'b1;
    tick(1, 0, 1);
    for (int i = 0; i < 40; i++) tick(0, 0, 1);
    expect_bit("R1 idle active", active, 1'b0);
    expect_bit("R1 idle err", cfg_err, 1'b0);

    // Frame A: legal minimum starts, single size
    vstart = 8'h14; hstart = 9'h19; hdbl = '0; vdbl = '0;
    req = "R9"; tick(0, 1, 0);
    expect_bit("R9 legal err", cfg_err, 1'b0);
    req = "R2";
    for (int i = 1; i < 20; i++) line(5);
    req = "R3"; line(34 + 480 + 4);
    req = "R11";
    for (int i = 0; i < 12; i++) line(36);
    req = "R6";
    for (int i = 0; i < 13 * 15; i++) line(40);
    for (int i = 0; i < 12; i++) line(40);
    req = "R4"; line(34 + 480 + 4);
    req = "R6";
    for (int i = 0; i < 3; i++) line(40);

    // Frame B: clamped horizontal start, mixed sizes, mid-frame register changes
    vstart = 8'h16; hstart = 9'h10;
    hdbl = 17'b00000000000000101; vdbl = 17'b10000000000000010;
    req = "R9"; tick(0, 1, 0);
    expect_bit("R9 clamp err", cfg_err, 1'b1);
    req = "R8";
    vstart = 8'h30; hstart = 9'h40; hdbl = '1; vdbl = '1;
    for (int i = 1; i < 22; i++) line(5);
    req = "R5"; line(34 + 960 + 3);
    req = "R7";
    for (int i = 0; i < 12; i++) line(60);
    for (int i = 0; i < 26; i++) line(40);
    req = "R10";
    tick(1, 0, 0);
    for (int i = 0; i < 120; i++) tick(0, 0, (i % 3) != 0);
    tick(1, 0, 1);
    for (int i = 0; i < 50; i++) tick(0, 0, 1);
    tick(0, 0, 0); tick(0, 0, 0);
    req = "R5"; line(34 + 960 + 3);
    req = "R7";
    for (int i = 0; i < 13 * 14 - 2; i++) line(38);
    for (int i = 0; i < 28; i++) line(40);

    // Frame C: coincident strobes, legal starts, vsync mid-display
    vstart = 8'h15; hstart = 9'h20; hdbl = '0; vdbl = '0;
    req = "R10"; tick(1, 1, 1);
    expect_bit("R10 err cleared", cfg_err, 1'b0);
    req = "R2";
    for (int i = 1; i < 24; i++) line(50);
    tick(1, 0, 0);
    for (int i = 0; i < 45; i++) tick(0, 0, 1);
    vstart = 8'h00;
    req = "R2"; tick(0, 1, 1);
    expect_bit("R2 vsync blanks", active, 1'b0);
    expect_bit("R9 low vstart err", cfg_err, 1'b1);
    for (int i = 1; i < 23; i++) line(45);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule